// File: doc/BRIEF.md
# Processor interrupt level resolver

This block sits beside a processor's trap logic and turns the raw interrupt sources into one hard-interrupt request. It merges a 16-bit vector of external level lines with a software-interrupt register. The two timer-match bits of that register are not treated as levels of their own: either of them raises level 14. The merged pending set is then weighed against the processor's current priority threshold.

When the request is high, the latched trap type tells the trap logic which level interrupt to take. The trap type is the external-interrupt group base 0x40 combined with the level number. The block evaluates its inputs on every clock and updates its registered outputs one cycle later.

Three conditions decide what happens to the request:
- While a vector interrupt is busy, all level interrupts are masked and the outputs hold.
- When the interrupt enable is off, an outstanding request is withdrawn.
- While the processor is already inside a higher external-interrupt trap, a new request is held back.

Top module: `lvl_resolver`

## Requirements
- R1: The pending set is the external level vector ORed with the software-interrupt register, with software bits 0 and 16 left out. External bit n and software bit n both stand for level n.
- R2: If software bit 0 or software bit 16 is set, level 14 is added to the pending set.
- R3: While `vec_busy` is 1, `irq_req` and `irq_tt` keep their values whatever the other inputs do.
- R4: When not busy, if the pending set read as a number is below 2 shifted left by `thresh`, the request drops to 0 and `irq_tt` clears to 0.
- R5: When not busy, enabled and not below the limit of R4, the highest pending level L with `thresh` < L <= 15 is chosen. The candidate trap type is 0x40 | L.
- R6: The candidate is not raised, and the outputs hold, when all of the following are true:
  - `trap_lvl` is nonzero;
  - `cur_tt` AND 0x1F0 equals 0x40;
  - `cur_tt` is strictly greater than the candidate.
- R7: Outside R6, the outputs change to `irq_req`=1 and `irq_tt`=candidate only when the candidate differs from the latched `irq_tt`. A changed candidate is latched even when it is lower than the latched one.
- R8: When not busy and `int_en` is 0, the request drops to 0 and `irq_tt` clears to 0.
- R9: A synchronous active-low reset clears `irq_req` and `irq_tt` to 0. `irq_tt` is nonzero exactly when `irq_req` is 1.
- R10: The outputs respond to an input change at the first rising clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_lvl | input | 16 | External level lines, bit n is level n |
| soft_int | input | 17 | Software-interrupt register, bits 0 and 16 are timer matches |
| thresh | input | 4 | Current priority threshold |
| int_en | input | 1 | Global interrupt enable |
| vec_busy | input | 1 | Vector interrupt pending, masks level interrupts |
| trap_lvl | input | 3 | Current trap nesting level |
| cur_tt | input | 9 | Trap type being serviced at the current trap level |
| irq_req | output | 1 | Registered hard-interrupt request |
| irq_tt | output | 8 | Registered trap-type index, 0x40 or level |

## Verification
The properties assume that every input is a plain, settled value at each rising edge. The threshold and nesting properties also assume that `cur_tt` is meaningful only while `trap_lvl` is nonzero. The software register is taken to be exactly 17 bits wide, so no pending bit lies above level 16. The bench changes every input only on the falling edge, keeps `soft_int` within those 17 bits, and sets `cur_tt` to values inside and outside the 0x40 group so that both sides of the nesting rule are reached.

// File: rtl/lvl_resolver_pkg.sv
// Package: shared constants for the interrupt level resolver.
// Assumes an 8-bit trap-type index whose upper nibble names the group.
package lvl_resolver_pkg;
    localparam int unsigned TT_W       = 8;
    localparam int unsigned CTT_W      = 9;
    localparam logic [TT_W-1:0]  LVL_TT_BASE = 8'h40;
    localparam logic [CTT_W-1:0] GRP_MASK    = 9'h1F0;
    localparam logic [CTT_W-1:0] GRP_LVL     = 9'h040;

    // Build a trap type from a level number.
    function automatic logic [TT_W-1:0] mk_tt(input logic [3:0] lvl);
        return LVL_TT_BASE | {4'h0, lvl};
    endfunction
endpackage

// File: rtl/lvl_pend_merge.sv
// Merges external levels and software bits into one pending vector.
// The two timer-match software bits are removed from their own positions
// and folded onto FOLD_LVL. Assumes SOFT_W > LVL_W and both match bits < SOFT_W.
module lvl_pend_merge #(
    parameter int unsigned LVL_W    = 16,
    parameter int unsigned SOFT_W   = 17,
    parameter int unsigned TICK_B   = 0,
    parameter int unsigned STICK_B  = 16,
    parameter int unsigned FOLD_LVL = 14
) (
    input  logic [LVL_W-1:0]  ext_lvl,
    input  logic [SOFT_W-1:0] soft_int,
    output logic [SOFT_W-1:0] pend
);
    logic [SOFT_W-1:0] match_msk;
    logic [SOFT_W-1:0] fold_bit;
    logic              any_match;

    // Purpose: locate the timer-match bits and the fold level.
    always_comb begin
        match_msk          = '0;
        match_msk[TICK_B]  = 1'b1;
        match_msk[STICK_B] = 1'b1;
        any_match          = |(soft_int & match_msk);
        fold_bit           = '0;
        fold_bit[FOLD_LVL] = any_match;
    end

    // Purpose: form the merged pending set.
    always_comb begin
        pend = {{(SOFT_W-LVL_W){1'b0}}, ext_lvl} | (soft_int & ~match_msk) | fold_bit;
    end
endmodule

// File: rtl/lvl_scan.sv
// Finds the highest pending level strictly above the threshold.
// Assumes LVL_W is a power of two so the threshold spans all levels.
module lvl_scan #(
    parameter int unsigned LVL_W = 16,
    localparam int unsigned THR_W = $clog2(LVL_W)
) (
    input  logic [LVL_W-1:0] pend,
    input  logic [THR_W-1:0] thresh,
    output logic             hit,
    output logic [THR_W-1:0] lvl
);
    logic [LVL_W-1:0] qual;

    // One qualifier per level: pending and above the threshold.
    for (genvar g = 0; g < LVL_W; g++) begin : g_qual
        assign qual[g] = pend[g] && (THR_W'(g) > thresh);
    end

    // Purpose: priority pick, the highest qualified level wins.
    always_comb begin
        lvl = '0;
        for (int i = 0; i < LVL_W; i++) begin
            if (qual[i]) lvl = THR_W'(i);
        end
        hit = |qual;
    end
endmodule

// File: rtl/lvl_nest_guard.sv
// Decides whether a new level request must be held back because an
// external-interrupt trap of higher type is being serviced.
// Assumes cur_tt is meaningful only when trap_lvl is nonzero.
module lvl_nest_guard
    import lvl_resolver_pkg::*;
#(
    parameter int unsigned TL_W = 3
) (
    input  logic [TL_W-1:0]  trap_lvl,
    input  logic [CTT_W-1:0] cur_tt,
    input  logic [TT_W-1:0]  cand_tt,
    output logic             hold_off
);
    // Purpose: compare the serviced trap against the candidate.
    always_comb begin
        hold_off = (trap_lvl != '0)
                && ((cur_tt & GRP_MASK) == GRP_LVL)
                && (cur_tt > {{(CTT_W-TT_W){1'b0}}, cand_tt});
    end
endmodule

// File: rtl/lvl_resolver.sv
// Top of the interrupt level resolver: merges sources, tests the threshold,
// picks a level, applies the nesting guard and latches request and trap type.
// Assumes synchronous inputs; outputs follow one clock after the inputs.
module lvl_resolver
    import lvl_resolver_pkg::*;
#(
    parameter int unsigned LVL_W  = 16,
    parameter int unsigned SOFT_W = 17,
    parameter int unsigned TL_W   = 3,
    localparam int unsigned THR_W = $clog2(LVL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  ext_lvl,
    input  logic [SOFT_W-1:0] soft_int,
    input  logic [THR_W-1:0]  thresh,
    input  logic              int_en,
    input  logic              vec_busy,
    input  logic [TL_W-1:0]   trap_lvl,
    input  logic [CTT_W-1:0]  cur_tt,
    output logic              irq_req,
    output logic [TT_W-1:0]   irq_tt
);
    logic [SOFT_W-1:0] pend;
    logic [SOFT_W+1:0] limit;
    logic              below;
    logic              hit;
    logic [THR_W-1:0]  lvl;
    logic [TT_W-1:0]   cand_tt;
    logic              hold_off;
    logic              req_nx;
    logic [TT_W-1:0]   tt_nx;

    lvl_pend_merge #(.LVL_W(LVL_W), .SOFT_W(SOFT_W)) u_merge (
        .ext_lvl (ext_lvl),
        .soft_int(soft_int),
        .pend    (pend)
    );

    lvl_scan #(.LVL_W(LVL_W)) u_scan (
        .pend  (pend[LVL_W-1:0]),
        .thresh(thresh),
        .hit   (hit),
        .lvl   (lvl)
    );

    // Purpose: threshold limit test on the whole pending set.
    always_comb begin
        limit   = (SOFT_W+2)'(2) << thresh;
        below   = {2'b00, pend} < limit;
        cand_tt = mk_tt(4'(lvl));
    end

    lvl_nest_guard #(.TL_W(TL_W)) u_guard (
        .trap_lvl(trap_lvl),
        .cur_tt  (cur_tt),
        .cand_tt (cand_tt),
        .hold_off(hold_off)
    );

    // Purpose: next request and trap type from the decision order.
    always_comb begin
        req_nx = irq_req;
        tt_nx  = irq_tt;
        if (!vec_busy) begin
            if (below || !int_en) begin
                req_nx = 1'b0;
                tt_nx  = '0;
            end else if (hit && !hold_off && (cand_tt != irq_tt)) begin
                req_nx = 1'b1;
                tt_nx  = cand_tt;
            end
        end
    end

    // Purpose: output registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_tt  <= '0;
        end else begin
            irq_req <= req_nx;
            irq_tt  <= tt_nx;
        end
    end
endmodule

// File: rtl/lvl_resolver_chk.sv
// Checker for lvl_resolver, attached by bind. Observes ports only.
module lvl_resolver_chk #(
    parameter int unsigned LVL_W  = 16,
    parameter int unsigned SOFT_W = 17,
    parameter int unsigned TL_W   = 3,
    localparam int unsigned THR_W = $clog2(LVL_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LVL_W-1:0]  ext_lvl,
    input logic [SOFT_W-1:0] soft_int,
    input logic [THR_W-1:0]  thresh,
    input logic              int_en,
    input logic              vec_busy,
    input logic [TL_W-1:0]   trap_lvl,
    input logic [8:0]        cur_tt,
    input logic              irq_req,
    input logic [7:0]        irq_tt
);
    logic [SOFT_W-1:0] pend_c;
    logic              low_c;

    // Purpose: checker-side view of the pending set and threshold test.
    always_comb begin
        pend_c     = {{(SOFT_W-LVL_W){1'b0}}, ext_lvl} | soft_int;
        pend_c[0]  = ext_lvl[0];
        pend_c[16] = 1'b0;
        if (soft_int[0] || soft_int[16]) pend_c[14] = 1'b1;
        low_c = {2'b00, pend_c} < ((SOFT_W+2)'(2) << thresh);
    end

    a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        vec_busy |=> ($stable(irq_req) && $stable(irq_tt)));

    a_r4_below_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_busy && low_c) |=> (!irq_req && irq_tt == 8'h00));

    a_r8_disabled_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_busy && !int_en) |=> (!irq_req && irq_tt == 8'h00));

    a_r5_raise_above_thr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> (irq_tt[7:4] == 4'h4 && irq_tt[3:0] > $past(thresh)));

    a_r6_nested_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_busy && int_en && !low_c && trap_lvl != '0 && cur_tt == 9'h04F && !pend_c[15])
        |=> ($stable(irq_req) && $stable(irq_tt)));

    a_r9_tt_matches_req: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (irq_tt != 8'h00));
endmodule

bind lvl_resolver lvl_resolver_chk #(.LVL_W(LVL_W), .SOFT_W(SOFT_W), .TL_W(TL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_lvl(ext_lvl), .soft_int(soft_int),
    .thresh(thresh), .int_en(int_en), .vec_busy(vec_busy), .trap_lvl(trap_lvl),
    .cur_tt(cur_tt), .irq_req(irq_req), .irq_tt(irq_tt)
);

// File: tb/sim_lvl_resolver.sv
// Directed bench for lvl_resolver: one task per scenario.
module sim_lvl_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ext_lvl = '0;
    logic [16:0] soft_int = '0;
    logic [3:0]  thresh = '0;
    logic        int_en = 1'b0;
    logic        vec_busy = 1'b0;
    logic [2:0]  trap_lvl = '0;
    logic [8:0]  cur_tt = '0;
    logic        irq_req;
    logic [7:0]  irq_tt;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lvl_resolver u0 (
        .clk(clk), .rst_n(rst_n), .ext_lvl(ext_lvl), .soft_int(soft_int),
        .thresh(thresh), .int_en(int_en), .vec_busy(vec_busy), .trap_lvl(trap_lvl),
        .cur_tt(cur_tt), .irq_req(irq_req), .irq_tt(irq_tt)
    );

    task automatic check(input string tag, input logic er, input logic [7:0] et);
        n_chk++;
        if (irq_req !== er || irq_tt !== et) begin
            n_bad++;
            $display("FAIL %s: req=%0b tt=%02h expected req=%0b tt=%02h", tag, irq_req, irq_tt, er, et);
        end
    endtask

    // Drive on the falling edge, then sample just after the next rising edge.
    task automatic step(input logic [15:0] e, input logic [16:0] s, input logic [3:0] t,
                        input logic en, input logic bz, input logic [2:0] tl, input logic [8:0] ct);
        @(negedge clk);
        ext_lvl = e; soft_int = s; thresh = t; int_en = en; vec_busy = bz;
        trap_lvl = tl; cur_tt = ct;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        check("R9 reset state", 1'b0, 8'h00);
    endtask

    task automatic t_latency();
        @(negedge clk);
        ext_lvl = 16'h0020; thresh = 4'd2; int_en = 1'b1;
        #1;
        check("R10 no change before edge", 1'b0, 8'h00);
        @(posedge clk); #1;
        check("R10 change at first edge", 1'b1, 8'h45);
    endtask

    task automatic t_pick();
        step(16'h1208, '0, 4'd2, 1, 0, 0, 0);
        check("R5 highest level chosen", 1'b1, 8'h4C);
    endtask

    task automatic t_thresh();
        step(16'h0010, '0, 4'd4, 1, 0, 0, 0);
        check("R4 below limit clears", 1'b0, 8'h00);
        step(16'h0010, '0, 4'd3, 1, 0, 0, 0);
        check("R4 at limit raises", 1'b1, 8'h44);
        step(16'h8000, '0, 4'd15, 1, 0, 0, 0);
        check("R4 threshold 15 masks all", 1'b0, 8'h00);
    endtask

    task automatic t_fold();
        step('0, 17'h00001, 4'd5, 1, 0, 0, 0);
        check("R2 tick match folds to 14", 1'b1, 8'h4E);
        step('0, '0, 4'd5, 1, 0, 0, 0);
        check("R4 empty set clears", 1'b0, 8'h00);
        step('0, 17'h10000, 4'd5, 1, 0, 0, 0);
        check("R2 system tick folds to 14", 1'b1, 8'h4E);
        step('0, 17'h00001, 4'd14, 1, 0, 0, 0);
        check("R2 folded 14 below threshold 14", 1'b0, 8'h00);
    endtask

    task automatic t_merge();
        step('0, 17'h00080, 4'd2, 1, 0, 0, 0);
        check("R1 software level 7", 1'b1, 8'h47);
        step(16'h0004, 17'h00100, 4'd1, 1, 0, 0, 0);
        check("R1 merged pick level 8", 1'b1, 8'h48);
        step('0, 17'h10000, 4'd15, 1, 0, 0, 0);
        check("R1 bit 16 not a level", 1'b0, 8'h00);
    endtask

    task automatic t_busy();
        step(16'h0040, '0, 4'd2, 1, 0, 0, 0);
        check("R5 level 6", 1'b1, 8'h46);
        step('0, '0, 4'd2, 1, 1, 0, 0);
        check("R3 busy holds on empty", 1'b1, 8'h46);
        step(16'h0800, '0, 4'd2, 0, 1, 0, 0);
        check("R3 busy holds on change", 1'b1, 8'h46);
        step(16'h0800, '0, 4'd2, 1, 0, 0, 0);
        check("R3 release picks level 11", 1'b1, 8'h4B);
    endtask

    task automatic t_disable();
        step(16'h0800, '0, 4'd2, 0, 0, 0, 0);
        check("R8 disable clears", 1'b0, 8'h00);
        step(16'h0800, '0, 4'd2, 0, 0, 0, 0);
        check("R8 stays clear", 1'b0, 8'h00);
        step(16'h0800, '0, 4'd2, 1, 0, 0, 0);
        check("R8 enable raises", 1'b1, 8'h4B);
    endtask

    task automatic t_nest();
        step(16'h0008, '0, 4'd2, 1, 0, 0, 9'h000);
        check("R6 setup level 3", 1'b1, 8'h43);
        step(16'h0040, '0, 4'd2, 1, 0, 3'd1, 9'h048);
        check("R6 higher serviced suppresses", 1'b1, 8'h43);
        step(16'h0040, '0, 4'd2, 1, 0, 3'd1, 9'h148);
        check("R6 outside group not suppressed", 1'b1, 8'h46);
        step(16'h0020, '0, 4'd2, 1, 0, 3'd1, 9'h045);
        check("R6 equal type not suppressed", 1'b1, 8'h45);
        step(16'h0010, '0, 4'd2, 1, 0, 3'd0, 9'h04F);
        check("R6 trap level zero not suppressed", 1'b1, 8'h44);
        step(16'h0008, '0, 4'd2, 1, 0, 3'd2, 9'h04F);
        check("R6 nested level 2 suppresses", 1'b1, 8'h44);
    endtask

    task automatic t_same();
        step(16'h0200, '0, 4'd2, 1, 0, 0, 0);
        check("R7 new type latched", 1'b1, 8'h49);
        step(16'h0201, '0, 4'd2, 1, 0, 0, 0);
        check("R7 same type keeps", 1'b1, 8'h49);
        step(16'h0011, '0, 4'd2, 1, 0, 0, 0);
        check("R7 lower differing type latched", 1'b1, 8'h44);
    endtask

    task automatic t_rereset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R9 reset clears active request", 1'b0, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_latency();
        t_pick();
        t_thresh();
        t_fold();
        t_merge();
        t_busy();
        t_disable();
        t_nest();
        t_same();
        t_rereset();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule